// File: doc/BRIEF.md
# Write FIFO Status Sequencer

This block produces the three status flags that a peripheral bus write buffer reports to software: input pending, transfer in progress and drain. No data is stored. Each write strobe starts a timed sequence. The input-pending flag rises at once. The transfer flag follows some cycles later, and the drain flag comes after that. Each flag then drops once its own hold time has run out.

When writes come back to back, the sequence is stretched, not restarted. A write that arrives while a flag's drop is still scheduled pushes that drop out by the flag's hold time. A rise that is already scheduled is never moved. Each time is kept as a saturating down-counter of remaining cycles. Software reads the flags in an 8-bit status byte. Input pending is on bit 5, transfer on bit 4 and drain on bit 0. One tick is one clock cycle.

Top module: `wfifo_status_seq`

## Requirements
- R1: A write strobe seen at a clock edge sets status bit 5 (input pending) from that edge on.
- R2: Bit 5 falls 60 cycles after the write edge that set it. Each further write while its fall is scheduled moves that fall 60 cycles later.
- R3: A write that finds no transfer rise scheduled schedules bit 4 to rise 60 cycles after the write. An already scheduled rise is not moved by later writes.
- R4: Bit 4 falls 160 cycles after its scheduled rise. Each write while that fall is scheduled moves it 160 cycles later.
- R5: A write that finds no drain rise scheduled schedules bit 0 to rise 120 cycles after the write. An already scheduled rise is not moved.
- R6: Bit 0 falls 420 cycles after its scheduled rise. Each write while that fall is scheduled moves it 420 cycles later.
- R7: A deadline that has expired is inactive. With no further write, the status byte stays unchanged.
- R8: The remaining time of any deadline saturates at 2^CNT_W-1 cycles (65535 by default) and never wraps.
- R9: Status bits 7, 6, 3, 2 and 1 always read 0.
- R10: A synchronous active-low reset clears all flags and cancels every deadline. A write during reset has no effect.
- R11: A write on the very edge at which a fall would expire extends that fall, so the flag stays high. A scheduled rise due on that edge still happens on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one tick |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One pulse per bus write |
| status | output | 8 | Bit 5 input pending, bit 4 transfer, bit 0 drain, rest 0 |

## Verification
A wrong counter value inside this block does not show at once. It shows at the port only when a flag rises or falls at the wrong edge. That can be up to 540 cycles after one write, and far longer after a burst. A counter that wraps on overflow would clear the drain flag tens of thousands of cycles early. For these reasons the bench compares the whole status byte on every cycle against a model built on absolute deadlines. The bench also runs each sequence until every flag has settled.

// File: rtl/wfifo_seq_pkg.sv
// Package: shared constants for the write FIFO status sequencer.
// Assumes: status bit positions are fixed by the software view of the byte.
package wfifo_seq_pkg;
    localparam int unsigned DEF_CNT_W        = 16;
    localparam int unsigned DEF_IN_HOLD      = 60;
    localparam int unsigned DEF_XFER_DELAY   = 60;
    localparam int unsigned DEF_XFER_HOLD    = 160;
    localparam int unsigned DEF_DRAIN_DELAY  = 120;
    localparam int unsigned DEF_DRAIN_HOLD   = 420;
    localparam int unsigned STATUS_W         = 8;
    localparam int unsigned BIT_IN_PEND      = 5;
    localparam int unsigned BIT_XFER         = 4;
    localparam int unsigned BIT_DRAIN        = 0;
endpackage

// File: rtl/wfifo_deadline.sv
// Module: one saturating deadline counter.
// Holds the cycles left until an event. When inactive, a write arms it with
// arm_val. When active it counts down one per cycle. If EXTEND is set, a write
// while active adds inc_val, saturating at all ones. remain_nxt is the count
// after this edge; it reads zero while active on the edge where the event fires.
// Assumes: arm_val is nonzero whenever a write can arm the counter.
module wfifo_deadline #(
    parameter int unsigned CNT_W  = 16,
    parameter bit          EXTEND = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] arm_val,
    input  logic [CNT_W-1:0] inc_val,
    output logic             active,
    output logic [CNT_W-1:0] remain_nxt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_dec;
    logic [CNT_W-1:0] cnt_ext;
    logic [CNT_W:0]   ext_sum;
    logic             active_nxt;

    // Purpose: one tick of countdown and the saturated extension value.
    always_comb begin
        cnt_dec = cnt - 1'b1;
        ext_sum = {1'b0, cnt_dec} + {1'b0, inc_val};
        cnt_ext = ext_sum[CNT_W] ? CNT_MAX : ext_sum[CNT_W-1:0];
    end

    // Purpose: choose arm, extend, count or expire for this edge.
    always_comb begin
        active_nxt = active;
        remain_nxt = '0;
        if (active) begin
            if (wr && EXTEND) begin
                remain_nxt = cnt_ext;
            end else begin
                remain_nxt = cnt_dec;
                active_nxt = (cnt_dec != '0);
            end
        end else if (wr) begin
            remain_nxt = arm_val;
            active_nxt = 1'b1;
        end
    end

    // Purpose: register the count and its live bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
        end else begin
            cnt    <= remain_nxt;
            active <= active_nxt;
        end
    end

    // R8: a live counter never holds zero.
    a_r8_live_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt != '0));

    // R8: an extension saturates, so it cannot wrap into an expiry.
    a_r8_extend_keeps_live: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr && EXTEND) |=> active);

    // R7: an idle deadline stays idle without a write.
    a_r7_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !wr) |=> !active);
endmodule

// File: rtl/wfifo_lane.sv
// Module: one status flag with its scheduling.
// With HAS_RISE, a rise deadline is armed first (RISE_TICKS). The fall
// deadline is armed at rise + HOLD_TICKS. Otherwise the flag rises on the
// write itself and only the fall deadline exists. A write while the fall is
// live pushes it by HOLD_TICKS.
// Assumes: HOLD_TICKS > 0 and RISE_TICKS > 0 when HAS_RISE is set.
module wfifo_lane #(
    parameter int unsigned CNT_W      = 16,
    parameter bit          HAS_RISE   = 1'b1,
    parameter int unsigned RISE_TICKS = 60,
    parameter int unsigned HOLD_TICKS = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    output logic flag
);
    localparam logic [CNT_W-1:0] RISE_V = CNT_W'(RISE_TICKS);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_TICKS);

    logic             set_flag;
    logic [CNT_W-1:0] fall_arm;
    logic             fall_live;
    logic [CNT_W-1:0] fall_rem;
    logic             clr_flag;

    generate
        if (HAS_RISE) begin : g_rise
            logic             rise_live;
            logic [CNT_W-1:0] rise_rem;
            logic [CNT_W:0]   arm_sum;

            wfifo_deadline #(.CNT_W(CNT_W), .EXTEND(1'b0)) u_rise (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr        (wr),
                .arm_val   (RISE_V),
                .inc_val   ('0),
                .active    (rise_live),
                .remain_nxt(rise_rem)
            );

            // Purpose: fall time is the rise time plus the hold, saturated.
            always_comb begin
                arm_sum  = {1'b0, rise_rem} + {1'b0, HOLD_V};
                fall_arm = arm_sum[CNT_W] ? '1 : arm_sum[CNT_W-1:0];
                set_flag = rise_live && (rise_rem == '0);
            end

            // R3 / R5: a flag only rises with its fall already scheduled.
            a_r3_rise_has_fall: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag) |-> fall_live);
        end else begin : g_direct
            // Purpose: the flag follows the write at once; fall is a plain hold.
            always_comb begin
                fall_arm = HOLD_V;
                set_flag = wr;
            end
        end
    endgenerate

    wfifo_deadline #(.CNT_W(CNT_W), .EXTEND(1'b1)) u_fall (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr),
        .arm_val   (fall_arm),
        .inc_val   (HOLD_V),
        .active    (fall_live),
        .remain_nxt(fall_rem)
    );

    // Purpose: the fall fires when the live counter reaches zero on this edge.
    always_comb clr_flag = fall_live && (fall_rem == '0);

    // Purpose: the flag register; clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (clr_flag) begin
            flag <= 1'b0;
        end else if (set_flag) begin
            flag <= 1'b1;
        end
    end

    // R7: a flag that is high always has its fall scheduled.
    a_r7_high_has_fall: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> fall_live);
endmodule

// File: rtl/wfifo_status_seq.sv
// Module: top of the write FIFO status sequencer.
// Builds three flag lanes (input pending, transfer, drain) driven by one
// write strobe and packs them into the status byte.
// Assumes: one tick per clock; the strobe is synchronous to clk.
module wfifo_status_seq
    import wfifo_seq_pkg::*;
#(
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned IN_HOLD     = DEF_IN_HOLD,
    parameter int unsigned XFER_DELAY  = DEF_XFER_DELAY,
    parameter int unsigned XFER_HOLD   = DEF_XFER_HOLD,
    parameter int unsigned DRAIN_DELAY = DEF_DRAIN_DELAY,
    parameter int unsigned DRAIN_HOLD  = DEF_DRAIN_HOLD
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    output logic [7:0] status
);
    localparam logic [STATUS_W-1:0] USED_MASK =
        STATUS_W'((1 << BIT_IN_PEND) | (1 << BIT_XFER) | (1 << BIT_DRAIN));

    logic in_flag;
    logic xfer_flag;
    logic drain_flag;

    wfifo_lane #(.CNT_W(CNT_W), .HAS_RISE(1'b0), .RISE_TICKS(1),
                 .HOLD_TICKS(IN_HOLD)) u_in (
        .clk(clk), .rst_n(rst_n), .wr(wr_stb), .flag(in_flag)
    );

    wfifo_lane #(.CNT_W(CNT_W), .HAS_RISE(1'b1), .RISE_TICKS(XFER_DELAY),
                 .HOLD_TICKS(XFER_HOLD)) u_xfer (
        .clk(clk), .rst_n(rst_n), .wr(wr_stb), .flag(xfer_flag)
    );

    wfifo_lane #(.CNT_W(CNT_W), .HAS_RISE(1'b1), .RISE_TICKS(DRAIN_DELAY),
                 .HOLD_TICKS(DRAIN_HOLD)) u_drain (
        .clk(clk), .rst_n(rst_n), .wr(wr_stb), .flag(drain_flag)
    );

    // Purpose: place the flags at their fixed positions; spare bits are zero.
    always_comb begin
        status              = '0;
        status[BIT_IN_PEND] = in_flag;
        status[BIT_XFER]    = xfer_flag;
        status[BIT_DRAIN]   = drain_flag;
    end

    // R1: a write shows as input pending after its edge.
    a_r1_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> status[BIT_IN_PEND]);

    // R2: input pending never falls on an edge that saw a write.
    a_r2_fall_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[BIT_IN_PEND]) |-> !$past(wr_stb));

    // R9: spare bits stay low.
    a_r9_spare_low: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~USED_MASK) == '0);

    // R10: reset leaves an all-zero status.
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (status == '0));
endmodule

// File: tb/tb_wfifo_status_seq.sv
module tb_wfifo_status_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] status;

    localparam longint MAXC = 65535;

    int     n_chk = 0;
    int     n_fail = 0;
    longint e = 0;
    longint m_off5 = -1, m_on4 = -1, m_off4 = -1, m_on0 = -1, m_off0 = -1;
    logic   m5 = 1'b0, m4 = 1'b0, m0 = 1'b0;

    always #5 clk = ~clk;

    wfifo_status_seq dut (.clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .status(status));

    function automatic longint cap(longint v, longint lim);
        return (v > lim) ? lim : v;
    endfunction

    function automatic logic [7:0] mstat();
        return {2'b00, m5, m4, 3'b000, m0};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: status=%02h expected %02h at edge %0d", req, act, exp, e);
        end
    endtask

    task automatic chkb(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: bit=%0b expected %0b at edge %0d", req, act, exp, e);
        end
    endtask

    // Reference model on absolute edge numbers.
    task automatic model_edge(bit w, bit in_rst);
        e++;
        if (in_rst) begin
            m_off5 = -1; m_on4 = -1; m_off4 = -1; m_on0 = -1; m_off0 = -1;
            m5 = 1'b0; m4 = 1'b0; m0 = 1'b0;
            return;
        end
        if (w) begin
            m_off5 = (m_off5 >= e) ? cap(m_off5 + 60, e + MAXC) : e + 60;
            m_on4  = (m_on4 >= e) ? m_on4 : e + 60;
            m_off4 = (m_off4 >= e) ? cap(m_off4 + 160, e + MAXC) : m_on4 + 160;
            m_on0  = (m_on0 >= e) ? m_on0 : e + 120;
            m_off0 = (m_off0 >= e) ? cap(m_off0 + 420, e + MAXC) : m_on0 + 420;
            m5 = 1'b1;
        end
        if (m_off5 == e) m5 = 1'b0;
        if (m_on4 == e)  m4 = 1'b1;
        if (m_off4 == e) m4 = 1'b0;
        if (m_on0 == e)  m0 = 1'b1;
        if (m_off0 == e) m0 = 1'b0;
    endtask

    task automatic step(bit w, string req);
        bit in_rst;
        in_rst = !rst_n;
        wr_stb = w;
        @(posedge clk);
        model_edge(w, in_rst);
        @(negedge clk);
        wr_stb = 1'b0;
        chk(req, status, mstat());
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(1'b0, "R10 reset");
        step(1'b1, "R10 write in reset");
        step(1'b0, "R10 reset");
        chk("R10 idle after reset", status, 8'h00);
        rst_n = 1'b1;
        step(1'b0, "R9 spare bits");
        chk("R9 all zero idle", status, 8'h00);
    endtask

    task automatic t_single();
        step(1'b1, "R1 write");
        chkb("R1 set at once", status[5], 1'b1);
        for (int j = 1; j <= 620; j++) begin
            step(1'b0, "R7 single");
            chkb("R2 in-pending", status[5], j < 60);
            chkb("R3 xfer", status[4], (j >= 60) && (j < 220));
            chkb("R5 drain", status[0], (j >= 120) && (j < 540));
            chk("R9 spare", status & 8'hCE, 8'h00);
        end
        chk("R7 stays idle", status, 8'h00);
    endtask

    task automatic t_burst();
        for (int k = 0; k < 3; k++) begin
            step(1'b1, "R2 R4 R6 burst write");
            for (int i = 0; i < 9; i++) step(1'b0, "R3 R5 rise not moved");
        end
        for (int i = 0; i < 1500; i++) step(1'b0, "R4 R6 burst extend");
        chk("R7 burst idle", status, 8'h00);
    endtask

    task automatic t_edge();
        step(1'b1, "R11 first write");
        for (int i = 0; i < 59; i++) step(1'b0, "R11 wait");
        step(1'b1, "R11 write on expiry edge");
        chkb("R11 in-pending held", status[5], 1'b1);
        chkb("R11 xfer rises on due edge", status[4], 1'b1);
        for (int i = 0; i < 1100; i++) step(1'b0, "R11 tail");
    endtask

    task automatic t_sat();
        for (int i = 0; i < 200; i++) step(1'b1, "R8 saturating burst");
        chkb("R8 drain high", status[0], 1'b1);
        for (int i = 0; i < 65540; i++) step(1'b0, "R8 saturated drain");
        chk("R8 all cleared", status, 8'h00);
    endtask

    task automatic t_midreset();
        step(1'b1, "R10 write");
        for (int i = 0; i < 130; i++) step(1'b0, "R10 run");
        rst_n = 1'b0;
        step(1'b0, "R10 mid reset");
        chk("R10 cleared", status, 8'h00);
        rst_n = 1'b1;
        for (int i = 0; i < 700; i++) step(1'b0, "R10 R7 no retrigger");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_edge();
        t_sat();
        t_midreset();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule